// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept, using the destination address in its first six bytes. It holds a table of sixteen station addresses. A sixteen-bit mask says which table entries take part in matching. The frame arrives one byte per cycle with a start-of-frame marker. Once the sixth byte has been seen, the block gives an accept/reject verdict and a type code for the receive status word. Three accept modes are checked first, in a fixed order of priority: promiscuous, all-multicast and broadcast. The enabled table entries are checked after them.

The table is filled by a load sequence that reads a descriptor area through a simple word-read port, one word per handshake. The start pointer is a byte address, and an entry count says how many entries to load. Each entry takes an eight-byte slot. After the last slot, one more word supplies the enable mask. While the block is held in its software reset mode, a host can read any table entry back, two bytes at a time.

Top module: `rx_addr_filter`

## Requirements
- R1: With promiscuous mode on, every frame whose first destination byte has bit 0 clear is accepted with type 0x0000. Promiscuous mode alone does not accept a frame whose first destination byte has bit 0 set.
- R2: Where R1 does not apply and all-multicast mode is on, a frame whose first destination byte has bit 0 set is accepted with type 0x0100. This includes the all-ones address.
- R3: Where R1 and R2 do not apply and broadcast mode is on, a destination of all ones (0xFF in all six bytes) is accepted with type 0x0080.
- R4: Otherwise the frame is accepted with type 0x0000 when its destination equals a table entry whose bit in the enable mask is set (bit i enables entry i). An entry whose mask bit is clear never matches.
- R5: A frame that no rule accepts is rejected. Its type is 0x0000.
- R6: dec_valid pulses for exactly one cycle: the cycle after the clock edge that takes the sixth byte counted from rx_sof. The verdict and type are held until the next verdict. Bytes after the sixth produce no further verdict. A new rx_sof restarts the count from byte 0.
- R7: The load reads entry e from words at byte addresses ptr+8e+2, ptr+8e+4 and ptr+8e+6, in that order. The three words give address bytes 0/1, 2/3 and 4/5, with the low byte of each word holding the lower-numbered byte. An entry is only written after its read handshake completes (mem_rd and mem_rvalid both high). The request and address stay stable until that handshake.
- R8: After the entries, one word at ptr+8*count is read and becomes the enable mask. A count of zero reads only this mask word and leaves the entries unchanged.
- R9: load_busy rises the cycle after a load_start taken while idle. It falls in the same cycle that load_done pulses for one cycle, which is the cycle after the mask handshake. A load_start seen while busy is ignored.
- R10: While reset_mode is high, rd_data returns bytes 1/0, 3/2 or 5/4 of entry rd_idx for rd_sel 0, 1 or 2 (higher byte in bits 15:8). rd_sel 3, or reset_mode low, returns zero.
- R11: After rst_n, the table, the mask and all outputs are zero and the loader is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_promisc | input | 1 | Promiscuous accept mode |
| cfg_all_mcast | input | 1 | All-multicast accept mode |
| cfg_bcast | input | 1 | Broadcast accept mode |
| rx_valid | input | 1 | Frame byte present |
| rx_sof | input | 1 | This byte is byte 0 of a frame |
| rx_byte | input | 8 | Frame byte |
| dec_valid | output | 1 | Verdict pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_type | output | 16 | Type code: 0x0100 multicast, 0x0080 broadcast, else 0 |
| load_start | input | 1 | Start a table load |
| load_ptr | input | 16 | Byte address of the first slot |
| load_count | input | 5 | Number of entries to load |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | Load finished pulse |
| mem_rd | output | 1 | Word read request |
| mem_addr | output | 16 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid, completes the handshake |
| mem_rdata | input | 16 | Read data |
| en_mask | output | 16 | Entry enable mask |
| reset_mode | input | 1 | Software reset mode, allows readback |
| rd_idx | input | 4 | Entry index for readback |
| rd_sel | input | 2 | Byte pair for readback |
| rd_data | output | 16 | Readback data |

## Verification
The verdict is due exactly one clock after the edge that takes the sixth byte. Table writes and the mask update take effect at the edge of their read handshake, so the mask and readback values change in the next cycle; load_done and the falling edge of load_busy follow the mask handshake by one cycle. The bench's reference model advances at each rising edge from the same inputs and the memory handshake it sees on the ports. The bench compares every output with the model at the falling edge of every cycle, so a result that arrives one cycle early or late is reported. The memory responder inserts wait states, so the handshake timing is covered as well as the data.

// File: rtl/af_pkg.sv
package af_pkg;
    // Bytes in a station address and the resulting bit width
    localparam int unsigned MAC_BYTES = 6;
    localparam int unsigned MAC_W     = 8 * MAC_BYTES;
    // Type codes reported with the verdict
    localparam logic [15:0] TYPE_NONE  = 16'h0000;
    localparam logic [15:0] TYPE_MCAST = 16'h0100;
    localparam logic [15:0] TYPE_BCAST = 16'h0080;
    // Loader states
    typedef enum logic [1:0] {LD_IDLE, LD_ENTRY, LD_MASK} ld_state_e;
endpackage

// File: rtl/af_table.sv
// Address table: N_ENT station addresses plus an enable mask.
// Written one 16-bit byte pair at a time; the low byte holds the
// lower-numbered address byte. Assumes N_ENT <= DATA_W.
module af_table
    import af_pkg::*;
#(
    parameter int unsigned N_ENT  = 16,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned IW    = $clog2(N_ENT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  logic [1:0]             wr_pair,
    input  logic [DATA_W-1:0]      wr_word,
    input  logic                   mask_we,
    input  logic [N_ENT-1:0]       mask_in,
    output logic [N_ENT*MAC_W-1:0] entries,
    output logic [N_ENT-1:0]       mask
);
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        logic [MAC_W-1:0] ent_q;
        // Store one byte pair of this entry when addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (wr_en && wr_idx == IW'(e)) begin
                case (wr_pair)
                    2'd0:    ent_q[15:0]  <= wr_word[15:0];
                    2'd1:    ent_q[31:16] <= wr_word[15:0];
                    2'd2:    ent_q[47:32] <= wr_word[15:0];
                    default: ent_q <= ent_q;
                endcase
            end
        end
        assign entries[e*MAC_W +: MAC_W] = ent_q;
    end

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_in;
    end
endmodule

// File: rtl/af_loader.sv
// Load sequencer: walks count eight-byte slots from a start pointer,
// reads words 1..3 of each slot into the table and then reads one word
// as the enable mask. A word transfers when mem_rd and mem_rvalid are
// both high; the request holds until then.
module af_loader
    import af_pkg::*;
#(
    parameter int unsigned N_ENT  = 16,
    parameter int unsigned AW     = 16,
    parameter int unsigned CW     = 5,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned IW    = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_ptr,
    input  logic [CW-1:0]     start_cnt,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              tbl_we,
    output logic [IW-1:0]     tbl_idx,
    output logic [1:0]        tbl_pair,
    output logic [DATA_W-1:0] tbl_word,
    output logic              mask_we
);
    localparam int unsigned SLOT_BYTES = 8;

    ld_state_e     st;
    logic [AW-1:0] ptr;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic [1:0]    wsel;
    logic          xfer;

    // Request and address decode from the current state
    assign mem_rd   = (st != LD_IDLE);
    assign mem_addr = (st == LD_ENTRY) ? ptr + {{(AW-3){1'b0}}, wsel, 1'b0} : ptr;
    assign busy     = mem_rd;
    assign xfer     = mem_rd && mem_rvalid;
    assign tbl_we   = xfer && (st == LD_ENTRY);
    assign tbl_idx  = idx;
    assign tbl_pair = wsel - 2'd1;
    assign tbl_word = mem_rdata;
    assign mask_we  = xfer && (st == LD_MASK);

    // Sequence through slots, then the mask word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= LD_IDLE;
            ptr  <= '0;
            cnt  <= '0;
            idx  <= '0;
            wsel <= 2'd1;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                LD_IDLE: if (start) begin
                    ptr  <= start_ptr;
                    cnt  <= start_cnt;
                    idx  <= '0;
                    wsel <= 2'd1;
                    st   <= (start_cnt != '0) ? LD_ENTRY : LD_MASK;
                end
                LD_ENTRY: if (xfer) begin
                    if (wsel == 2'd3) begin
                        wsel <= 2'd1;
                        cnt  <= cnt - CW'(1);
                        ptr  <= ptr + AW'(SLOT_BYTES);
                        idx  <= idx + IW'(1);
                        st   <= (cnt == CW'(1)) ? LD_MASK : LD_ENTRY;
                    end else begin
                        wsel <= wsel + 2'd1;
                    end
                end
                LD_MASK: if (xfer) begin
                    st   <= LD_IDLE;
                    done <= 1'b1;
                end
                default: st <= LD_IDLE;
            endcase
        end
    end

    // R7: an open request keeps its address until the handshake
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && !mem_rvalid |=> mem_rd && $stable(mem_addr));
    // R9: the done pulse ends a busy period
    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));
endmodule

// File: rtl/af_match.sv
// Destination match: gathers the first MAC_BYTES bytes after rx_sof and,
// on the edge taking the last one, registers the verdict. Priority:
// promiscuous, all-multicast, broadcast, then masked table compare.
module af_match
    import af_pkg::*;
#(
    parameter int unsigned N_ENT = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid,
    input  logic                   rx_sof,
    input  logic [7:0]             rx_byte,
    input  logic                   promisc,
    input  logic                   all_mcast,
    input  logic                   bcast,
    input  logic [N_ENT*MAC_W-1:0] entries,
    input  logic [N_ENT-1:0]       mask,
    output logic                   dec_valid,
    output logic                   dec_accept,
    output logic [15:0]            dec_type
);
    localparam int unsigned PW = $clog2(MAC_BYTES + 1);

    logic [PW-1:0]      pos_cnt, pos;
    logic [MAC_W-9:0]   capt;
    logic [MAC_W-1:0]   dst;
    logic [N_ENT-1:0]   hit;
    logic               last, nx_acc;
    logic [15:0]        nx_type;

    assign pos  = rx_sof ? '0 : pos_cnt;
    assign last = rx_valid && (pos == PW'(MAC_BYTES - 1));
    assign dst  = {rx_byte, capt};

    // Per-entry compare gated by its enable bit
    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        assign hit[e] = mask[e] && (entries[e*MAC_W +: MAC_W] == dst);
    end

    // Fixed-priority verdict for the address now complete
    always_comb begin
        nx_acc  = 1'b0;
        nx_type = TYPE_NONE;
        if (promisc && !dst[0]) begin
            nx_acc = 1'b1;
        end else if (all_mcast && dst[0]) begin
            nx_acc  = 1'b1;
            nx_type = TYPE_MCAST;
        end else if (bcast && (&dst)) begin
            nx_acc  = 1'b1;
            nx_type = TYPE_BCAST;
        end else if (|hit) begin
            nx_acc = 1'b1;
        end
    end

    // Byte position counter and capture of the leading bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_cnt <= '0;
            capt    <= '0;
        end else if (rx_valid) begin
            if (pos < PW'(MAC_BYTES - 1)) capt[8*pos +: 8] <= rx_byte;
            if (pos < PW'(MAC_BYTES))     pos_cnt <= pos + PW'(1);
        end
    end

    // Verdict register, held between verdicts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_type   <= TYPE_NONE;
        end else begin
            dec_valid <= last;
            if (last) begin
                dec_accept <= nx_acc;
                dec_type   <= nx_type;
            end
        end
    end

    // R6: a verdict only follows a clock with a byte present
    a_r6_dec_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rx_valid));
    // R2: at most one type code bit is set
    a_r2_type_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $onehot0(dec_type));
    // R3: a typed verdict is always an accept
    a_r3_type_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_type != TYPE_NONE |-> dec_accept);
endmodule

// File: rtl/rx_addr_filter.sv
// Receive destination filter top: address table, load sequencer and
// matcher, plus byte-pair readback of one entry in reset mode.
module rx_addr_filter
    import af_pkg::*;
#(
    parameter int unsigned N_ENT  = 16,
    parameter int unsigned AW     = 16,
    parameter int unsigned CW     = 5,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned IW    = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_promisc,
    input  logic              cfg_all_mcast,
    input  logic              cfg_bcast,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_byte,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [15:0]       dec_type,
    input  logic              load_start,
    input  logic [AW-1:0]     load_ptr,
    input  logic [CW-1:0]     load_count,
    output logic              load_busy,
    output logic              load_done,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [N_ENT-1:0]  en_mask,
    input  logic              reset_mode,
    input  logic [IW-1:0]     rd_idx,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    logic [N_ENT*MAC_W-1:0] entries;
    logic                   tbl_we, mask_we;
    logic [IW-1:0]          tbl_idx;
    logic [1:0]             tbl_pair;
    logic [DATA_W-1:0]      tbl_word;
    logic [MAC_W-1:0]       rd_ent;

    af_loader #(.N_ENT(N_ENT), .AW(AW), .CW(CW), .DATA_W(DATA_W)) u_loader (
        .clk(clk), .rst_n(rst_n), .start(load_start), .start_ptr(load_ptr),
        .start_cnt(load_count), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(load_busy),
        .done(load_done), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_pair(tbl_pair), .tbl_word(tbl_word), .mask_we(mask_we)
    );

    af_table #(.N_ENT(N_ENT), .DATA_W(DATA_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(tbl_idx),
        .wr_pair(tbl_pair), .wr_word(tbl_word), .mask_we(mask_we),
        .mask_in(tbl_word[N_ENT-1:0]), .entries(entries), .mask(en_mask)
    );

    af_match #(.N_ENT(N_ENT)) u_match (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_byte(rx_byte), .promisc(cfg_promisc), .all_mcast(cfg_all_mcast),
        .bcast(cfg_bcast), .entries(entries), .mask(en_mask),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_type(dec_type)
    );

    // Readback mux, open only in reset mode
    assign rd_ent = entries[rd_idx*MAC_W +: MAC_W];
    always_comb begin
        rd_data = '0;
        if (reset_mode) begin
            case (rd_sel)
                2'd0:    rd_data = DATA_W'(rd_ent[15:0]);
                2'd1:    rd_data = DATA_W'(rd_ent[31:16]);
                2'd2:    rd_data = DATA_W'(rd_ent[47:32]);
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_promisc = 0, cfg_all_mcast = 0, cfg_bcast = 0;
    logic        rx_valid = 0, rx_sof = 0;
    logic [7:0]  rx_byte = '0;
    logic        dec_valid, dec_accept;
    logic [15:0] dec_type;
    logic        load_start = 0;
    logic [15:0] load_ptr = '0;
    logic [4:0]  load_count = '0;
    logic        load_busy, load_done, mem_rd;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] en_mask;
    logic        reset_mode = 0;
    logic [3:0]  rd_idx = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;

    rx_addr_filter dut (.*);

    always #4ns clk = ~clk;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string tag, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Backing memory, 256 words, byte addressed
    logic [15:0] mem [0:255];
    function automatic logic [15:0] mword(input logic [15:0] a);
        return mem[a[8:1]];
    endfunction

    // Reference model state
    logic [47:0] m_cam [0:15];
    logic [15:0] m_mask;
    bit          m_busy, m_done, m_dv, m_acc;
    logic [15:0] m_type;
    string       m_tag = "R5";
    int          m_pos;
    logic [47:0] m_da;
    int          q_addr[$];
    int          q_kind[$];

    function automatic void decide(input logic [47:0] d, output bit acc,
                                   output logic [15:0] ty, output string tag);
        acc = 0; ty = 16'h0000; tag = "R5";
        if (cfg_promisc && d[0] == 1'b0) begin acc = 1; tag = "R1"; end
        else if (cfg_all_mcast && d[0]) begin acc = 1; ty = 16'h0100; tag = "R2"; end
        else if (cfg_bcast && d == 48'hFFFF_FFFF_FFFF) begin acc = 1; ty = 16'h0080; tag = "R3"; end
        else begin
            for (int i = 0; i < 16; i++)
                if (m_mask[i] && m_cam[i] == d) begin acc = 1; tag = "R4"; end
        end
    endfunction

    // Model advances on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_cam[i] = '0;
            m_mask = '0; m_busy = 0; m_done = 0; m_dv = 0; m_acc = 0;
            m_type = '0; m_pos = 0; m_da = '0;
            q_addr.delete(); q_kind.delete();
        end else begin
            m_done = 0;
            m_dv = 0;
            if (load_start && !m_busy) begin
                m_busy = 1;
                for (int e = 0; e < int'(load_count); e++)
                    for (int w = 1; w <= 3; w++) begin
                        q_addr.push_back((int'(load_ptr) + 8*e + 2*w) & 16'hFFFF);
                        q_kind.push_back((e % 16) * 4 + (w - 1));
                    end
                q_addr.push_back((int'(load_ptr) + 8*int'(load_count)) & 16'hFFFF);
                q_kind.push_back(-1);
            end
            if (mem_rd && mem_rvalid) begin
                if (q_addr.size() == 0) begin
                    chk("R9", "read while idle", {47'd0, mem_rd}, 48'd0);
                end else begin
                    int a, k;
                    logic [15:0] wd;
                    a = q_addr.pop_front();
                    k = q_kind.pop_front();
                    chk(k < 0 ? "R8" : "R7", "read address", {32'd0, mem_addr}, 48'(a));
                    wd = mword(16'(a));
                    if (k < 0) begin
                        m_mask = wd; m_busy = 0; m_done = 1;
                    end else begin
                        m_cam[k/4][16*(k%4) +: 16] = wd;
                    end
                end
            end
            if (rx_valid) begin
                if (rx_sof) m_pos = 0;
                if (m_pos < 6) begin
                    m_da[8*m_pos +: 8] = rx_byte;
                    if (m_pos == 5) begin
                        m_dv = 1;
                        decide(m_da, m_acc, m_type, m_tag);
                    end
                    m_pos++;
                end
            end
        end
    end

    function automatic logic [15:0] exp_rd();
        if (!reset_mode || rd_sel == 2'd3) return 16'h0000;
        return m_cam[rd_idx][16*rd_sel +: 16];
    endfunction

    // Compare every output against the model on each falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R6", "dec_valid", {47'd0, dec_valid}, {47'd0, m_dv});
            chk(m_tag, "dec_accept", {47'd0, dec_accept}, {47'd0, m_acc});
            chk(m_tag, "dec_type", {32'd0, dec_type}, {32'd0, m_type});
            chk("R9", "load_busy", {47'd0, load_busy}, {47'd0, m_busy});
            chk("R9", "load_done", {47'd0, load_done}, {47'd0, m_done});
            chk("R8", "en_mask", {32'd0, en_mask}, {32'd0, m_mask});
            chk("R10", "rd_data", {32'd0, rd_data}, {32'd0, exp_rd()});
        end
    end

    // Memory responder with wait states: answers two cycles in three
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rvalid = mem_rd && (cyc % 3 != 0);
            mem_rdata  = mem_rvalid ? mword(mem_addr) : 16'h0000;
        end
    end

    task automatic send(input logic [47:0] da, input int extra);
        for (int i = 0; i < 6 + extra; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0);
            rx_byte = (i < 6) ? da[8*i +: 8] : 8'(8'hA0 + i);
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0;
        @(negedge clk);
    endtask

    task automatic pulse_load(input logic [15:0] p, input logic [4:0] c);
        @(negedge clk);
        load_start = 1; load_ptr = p; load_count = c;
        @(negedge clk);
        load_start = 0;
    endtask

    task automatic wait_idle();
        while (load_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic readback(input int e);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            rd_idx = 4'(e); rd_sel = 2'(s);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'((i * 16'h2F1B) ^ 16'h9C35);
        mem[8'h30] = 16'h000B;   // mask for the 4-entry load
        mem[8'h40] = 16'hFFFF;   // mask-only load
        mem[8'hC0] = 16'h8001;   // mask for the 16-entry load
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state at the ports
        chk("R11", "reset dec_valid", {47'd0, dec_valid}, 48'd0);
        chk("R11", "reset dec_type", {32'd0, dec_type}, 48'd0);
        chk("R11", "reset load_busy", {47'd0, load_busy}, 48'd0);
        chk("R11", "reset en_mask", {32'd0, en_mask}, 48'd0);
        chk("R11", "reset mem_rd", {47'd0, mem_rd}, 48'd0);

        // R7 R8 R9: four entries, mask 0x000B
        pulse_load(16'h0040, 5'd4);
        wait_idle();
        // R10: readback in reset mode and quiet outside it
        reset_mode = 1;
        for (int e = 0; e < 4; e++) readback(e);
        reset_mode = 0;
        readback(1);

        // R4 R5: table matches, disabled entry, unknown unicast
        send(m_cam[0], 0);
        send(m_cam[2], 0);
        send(m_cam[3], 4);          // R6: trailing bytes give no verdict
        send(48'h6655_4433_2210, 0);
        // R6: restart on a new start-of-frame
        @(negedge clk); rx_valid = 1; rx_sof = 1; rx_byte = 8'h12;
        @(negedge clk); rx_sof = 0; rx_byte = 8'h34;
        @(negedge clk); rx_byte = 8'h56;
        rx_valid = 0;
        send(m_cam[1], 0);

        // R1: promiscuous takes even first byte, not odd
        cfg_promisc = 1;
        send(48'h0102_0304_0510, 0);
        send(48'h0102_0304_0511, 0);
        cfg_promisc = 0;
        // R2: all-multicast, including all ones
        cfg_all_mcast = 1;
        send(48'hFFFF_FFFF_FFFF, 0);
        send(48'h1111_2222_3301, 0);
        cfg_all_mcast = 0;
        // R3: broadcast only for exactly all ones
        cfg_bcast = 1;
        send(48'hFFFF_FFFF_FFFF, 0);
        send(48'h7FFF_FFFF_FFFF, 0);
        send(48'hFFFF_FFFF_FFFE, 0);
        cfg_bcast = 0;

        // R8: count zero loads only the mask
        pulse_load(16'h0080, 5'd0);
        wait_idle();
        send(m_cam[2], 0);

        // R9: a second start during a load is ignored
        pulse_load(16'h0100, 5'd16);
        repeat (5) @(negedge clk);
        load_start = 1; load_ptr = 16'h0000; load_count = 5'd1;
        @(negedge clk);
        load_start = 0;
        wait_idle();
        reset_mode = 1;
        readback(15);
        readback(0);
        reset_mode = 0;
        send(m_cam[15], 0);
        send(m_cam[0], 0);
        send(m_cam[5], 0);
        repeat (4) @(negedge clk);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule